// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an internal request bus and an external 8192-word by 8-bit asynchronous static RAM. A client offers one read or write at a time with a valid/ready handshake. The sequencer then drives the RAM's address, its pair of chip selects (one active low, one active high), its active-low output and write strobes, and the direction of the shared data bus. Every strobe comes straight from a flop.

Each timing minimum or maximum of the RAM is a parameter in picoseconds. At elaboration each one is rounded up to a whole number of cycles of the design clock (`CLK_PS`). At the defaults (4 ns clock, fastest RAM grade) the results are these:
- A read keeps the RAM selected with its output enabled for 4 cycles.
- A write uses 1 setup cycle, then 3 cycles with the write strobe low, then 1 recovery cycle.

A read returns its byte with a one-cycle valid pulse. Between accesses the RAM is always deselected, which puts it into its low-power state.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, both RAM strobes `mem_oe_n` and `mem_we_n` are high (inactive), `mem_dq_oe` is 0 and `rsp_valid` is 0. `req_ready` is high only while no access is in progress.
- R2: The two chip selects always move together. Either `mem_ce1_n`=0 with `mem_ce2`=1 (selected), or `mem_ce1_n`=1 with `mem_ce2`=0 (deselected).
- R3: `mem_we_n` is low only while the RAM is selected and `mem_oe_n` is high. `mem_oe_n` stays high for the whole of a write access.
- R4: `mem_dq_oe` is 1 only while the RAM is selected with `mem_oe_n` high. It is 1 exactly from the cycle `mem_we_n` falls until the RAM is deselected.
- R5: A read returns on `rsp_rdata` the byte last written to that address. `mem_addr` does not change while the RAM stays selected.
- R6: During a write, `mem_we_n` stays low for exactly PW_CYC consecutive cycles (3 at the defaults). This is the largest of the rounded-up write-pulse, data-setup and address-setup-to-write-end counts.
- R7: When `mem_we_n` rises, `mem_dq_oe` is still 1 and `mem_dq_o` holds the same value it had in the cycle before.
- R8: A write keeps the RAM selected for SU_CYC+PW_CYC+RV_CYC cycles (1+3+1 = 5 at the defaults), which is at least the rounded-up write cycle time. `mem_we_n` falls after the SU_CYC setup cycles.
- R9: Each accepted read produces exactly one `rsp_valid` pulse, one cycle long. A write produces none.
- R10: A request held on `req_valid` while `req_ready` is low is accepted once, at the first clock edge where `req_ready` is high. It starts exactly one RAM access.
- R11: While no access is in progress the RAM is deselected: `mem_ce1_n`=1 and `mem_ce2`=0.
- R12: A read keeps the RAM selected with `mem_oe_n` low for exactly RD_CYC cycles (4 at the defaults). This is the largest of the rounded-up read-cycle, address-access, select-access and output-enable-access counts. The data is captured at the edge that ends this window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client offers a request |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_rdata` holds a read result |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 13 | RAM address |
| mem_ce1_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_o | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | 1 = sequencer drives the data bus |
| mem_dq_i | input | 8 | Data arriving from the RAM |

## Verification
The hardest case to reach is a request that arrives while an access is still in flight. It must wait, then be taken exactly once, without the address or data bus moving under the access that is running. The bench creates this situation by issuing requests back to back. The driver raises `req_valid` the cycle after the previous acceptance and holds it through the busy window. This mixes write-after-write, read-after-write and read-after-read. A bus model of the RAM measures every strobe window in cycles and commits writes only on the rising edge of the write strobe. As a result, any early data release or shortened pulse shows up as a wrong read-back or a wrong cycle count.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RD_WAIT,
      PH_WR_SETUP,
      PH_WR_PULSE,
      PH_WR_RECOVER
   } phase_e;

   // whole cycles covering a time in picoseconds
   function automatic int unsigned to_cycles(int unsigned t_ps, int unsigned clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned umax(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // subtraction that stops at zero
   function automatic int unsigned usub(int unsigned a, int unsigned b);
      return (a > b) ? a - b : 0;
   endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= load_val;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign done = (remain_q == '0);

   // the count only ever falls between loads
   a_r12_timer_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!load) && $past(remain_q) != '0) |-> remain_q == $past(remain_q) - 1'b1);

endmodule

// File: rtl/asram_phase_seq.sv
module asram_phase_seq
   import asram_ctrl_pkg::*;
#(
   parameter int unsigned CNT_W  = 3,
   parameter int unsigned RD_CYC = 4,
   parameter int unsigned SU_CYC = 1,
   parameter int unsigned PW_CYC = 3,
   parameter int unsigned RV_CYC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_done,
   output logic             req_ready,
   output logic             accept,
   output logic             capture,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             ce1_n,
   output logic             ce2,
   output logic             oe_n,
   output logic             we_n,
   output logic             dq_oe
);

   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SU_CYC - 1);
   localparam logic [CNT_W-1:0] PW_LD = CNT_W'(PW_CYC - 1);
   localparam logic [CNT_W-1:0] RV_LD = CNT_W'(RV_CYC - 1);

   phase_e ph_q, ph_d;

   assign req_ready = (ph_q == PH_IDLE);
   assign accept    = req_ready && req_valid;
   assign capture   = (ph_q == PH_RD_WAIT) && tmr_done;

   always_comb begin
      ph_d     = ph_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (ph_q)
         PH_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  ph_d    = PH_WR_SETUP;
                  tmr_val = SU_LD;
               end else begin
                  ph_d    = PH_RD_WAIT;
                  tmr_val = RD_LD;
               end
            end
         end
         PH_RD_WAIT: begin
            if (tmr_done) ph_d = PH_IDLE;
         end
         PH_WR_SETUP: begin
            if (tmr_done) begin
               ph_d     = PH_WR_PULSE;
               tmr_load = 1'b1;
               tmr_val  = PW_LD;
            end
         end
         PH_WR_PULSE: begin
            if (tmr_done) begin
               ph_d     = PH_WR_RECOVER;
               tmr_load = 1'b1;
               tmr_val  = RV_LD;
            end
         end
         PH_WR_RECOVER: begin
            if (tmr_done) ph_d = PH_IDLE;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   // strobes decoded from the next phase and registered, so pins never glitch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         ce1_n <= 1'b1;
         ce2   <= 1'b0;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         ce1_n <= (ph_d == PH_IDLE);
         ce2   <= (ph_d != PH_IDLE);
         oe_n  <= (ph_d != PH_RD_WAIT);
         we_n  <= (ph_d != PH_WR_PULSE);
         dq_oe <= (ph_d == PH_WR_PULSE) || (ph_d == PH_WR_RECOVER);
      end
   end

   // length of the current low stretch of the write strobe, saturating
   logic [CNT_W:0] we_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  we_run_q <= '0;
      else if (we_n)               we_run_q <= '0;
      else if (we_run_q != '1)     we_run_q <= we_run_q + 1'b1;
   end

   a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (oe_n && we_n && !dq_oe));
   a_r2_selects_pair: assert property (@(posedge clk) disable iff (!rst_n)
      ce1_n != ce2);
   a_r3_write_strobe_legal: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!ce1_n && ce2 && oe_n));
   a_r4_drive_legal: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!ce1_n && oe_n));
   a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (we_run_q == (CNT_W+1)'(PW_CYC)));
   a_r11_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ce1_n && !ce2));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
      end else if (accept) begin
         mem_addr <= req_addr;
         mem_dq_o <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_i;
      end
   end

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_valid && !$past(capture)) |-> $stable(rsp_rdata));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CLK_PS    = 4000,
   parameter int unsigned T_RC_PS   = 15000,
   parameter int unsigned T_AA_PS   = 15000,
   parameter int unsigned T_ACE_PS  = 15000,
   parameter int unsigned T_DOE_PS  = 8000,
   parameter int unsigned T_HZOE_PS = 7000,
   parameter int unsigned T_WC_PS   = 15000,
   parameter int unsigned T_PWE_PS  = 12000,
   parameter int unsigned T_AW_PS   = 12000,
   parameter int unsigned T_SD_PS   = 8000,
   parameter int unsigned T_SA_PS   = 0,
   parameter int unsigned T_HA_PS   = 0,
   parameter int unsigned T_HD_PS   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   // read window: the slowest of cycle time and the three access paths
   localparam int unsigned RD_CYC = umax(1, umax(umax(to_cycles(T_RC_PS, CLK_PS),
                                                      to_cycles(T_AA_PS, CLK_PS)),
                                                 umax(to_cycles(T_ACE_PS, CLK_PS),
                                                      to_cycles(T_DOE_PS, CLK_PS))));
   // setup: address settle plus room for the RAM to release the bus after OE rises
   // (the idle cycle before every write already gives one cycle of OE high)
   localparam int unsigned SU_CYC = umax(1, umax(to_cycles(T_SA_PS, CLK_PS),
                                                 usub(to_cycles(T_HZOE_PS, CLK_PS), 1)));
   localparam int unsigned PW_CYC = umax(1, umax(umax(to_cycles(T_PWE_PS, CLK_PS),
                                                      to_cycles(T_SD_PS, CLK_PS)),
                                                 usub(to_cycles(T_AW_PS, CLK_PS), SU_CYC)));
   localparam int unsigned RV_CYC = umax(1, umax(umax(to_cycles(T_HA_PS, CLK_PS),
                                                      to_cycles(T_HD_PS, CLK_PS)),
                                                 usub(to_cycles(T_WC_PS, CLK_PS), SU_CYC + PW_CYC)));
   localparam int unsigned MAX_CYC = umax(umax(RD_CYC, SU_CYC), umax(PW_CYC, RV_CYC));
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   if (CLK_PS == 0) begin : g_bad_clk
      $error("asram_ctrl: CLK_PS must be non-zero");
   end
   if (ADDR_W < 1 || ADDR_W > 31) begin : g_bad_addr
      $error("asram_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("asram_ctrl: DATA_W must be at least 1");
   end

   logic             accept, capture, tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;

   asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   asram_phase_seq #(
      .CNT_W  (CNT_W),
      .RD_CYC (RD_CYC),
      .SU_CYC (SU_CYC),
      .PW_CYC (PW_CYC),
      .RV_CYC (RV_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tmr_done  (tmr_done),
      .req_ready (req_ready),
      .accept    (accept),
      .capture   (capture),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .ce1_n     (mem_ce1_n),
      .ce2       (mem_ce2),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .dq_oe     (mem_dq_oe)
   );

   asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .capture   (capture),
      .mem_dq_i  (mem_dq_i),
      .mem_addr  (mem_addr),
      .mem_dq_o  (mem_dq_o),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
   a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));
   a_r12_capture_window: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n));
   a_r10_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !mem_ce1_n);

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

   localparam int AW = 13;
   localparam int DW = 8;
   localparam int RD = 4, SU = 1, PW = 3, RV = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_o, mem_dq_i;

   always #10 clk = ~clk;

   asram_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i)
   );

   int tests = 0, fails = 0;
   task automatic chk(bit ok, string tag, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- RAM bus model ----------------
   logic [DW-1:0] ram [int unsigned];
   function automatic logic [DW-1:0] fill_of(logic [AW-1:0] a);
      return a[7:0] ^ 8'h3C;
   endfunction

   always @(mem_addr or mem_ce1_n or mem_ce2 or mem_oe_n or mem_we_n) begin
      if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
         mem_dq_i = ram.exists(mem_addr) ? ram[mem_addr] : fill_of(mem_addr);
      else
         mem_dq_i = 'z;
   end

   // commit on the rising write strobe while still selected
   always @(posedge mem_we_n) begin
      if (rst_n && !mem_ce1_n && mem_ce2 && mem_dq_oe) ram[mem_addr] = mem_dq_o;
   end

   // ---------------- scoreboard ----------------
   logic [DW-1:0] exp_mem [int unsigned];
   logic [DW-1:0] exp_q [$];
   int n_reads = 0, n_req = 0, n_rsp = 0, n_sel = 0;

   task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      n_req++;
      if (wr) exp_mem[a] = d;
      else begin
         exp_q.push_back(exp_mem.exists(a) ? exp_mem[a] : fill_of(a));
         n_reads++;
      end
      forever begin
         if (req_ready) begin @(negedge clk); break; end
         @(negedge clk);
      end
      req_valid = 1'b0;
   endtask

   // ---------------- monitor ----------------
   int wlow = 0, olow = 0, sel_len = 0;
   bit in_wr = 0, prev_sel = 0, prev_we = 1, prev_rsp = 0;
   int we_fall_at = 0;
   logic [AW-1:0] prev_addr;
   logic [DW-1:0] prev_dq;
   int bad_r1 = 0, bad_r2 = 0, bad_r3 = 0, bad_r4 = 0, bad_r5 = 0, bad_r9 = 0, bad_r11 = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit sel;
         sel = !mem_ce1_n && mem_ce2;
         if (mem_ce1_n == mem_ce2) bad_r2++;
         if (!mem_we_n && (!sel || !mem_oe_n)) bad_r3++;
         if (mem_dq_oe && (!sel || !mem_oe_n)) bad_r4++;
         if (req_ready && (!mem_ce1_n || mem_ce2)) bad_r11++;
         if (req_ready && (!mem_oe_n || !mem_we_n || mem_dq_oe || sel)) bad_r1++;
         if (sel && prev_sel && mem_addr != prev_addr) bad_r5++;
         if (rsp_valid && prev_rsp) bad_r9++;

         if (rsp_valid) begin
            n_rsp++;
            if (exp_q.size() == 0) bad_r9++;
            else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               chk(rsp_rdata === e, "R5 read data", rsp_rdata, e);
            end
         end

         if (!mem_we_n) begin
            if (wlow == 0) we_fall_at = sel_len;
            wlow++;
         end else if (wlow > 0) begin
            chk(wlow == PW, "R6 write strobe width", wlow, PW);
            wlow = 0;
         end
         if (mem_we_n && !prev_we)
            chk(mem_dq_oe && mem_dq_o == prev_dq, "R7 data held at strobe rise",
                {mem_dq_oe, mem_dq_o}, {1'b1, prev_dq});

         if (!mem_oe_n) olow++;
         else if (olow > 0) begin
            chk(olow == RD, "R12 read window", olow, RD);
            olow = 0;
         end

         if (sel) begin
            if (!prev_sel) n_sel++;
            if (!mem_we_n) in_wr = 1;
            sel_len++;
         end else if (sel_len > 0) begin
            if (in_wr) begin
               chk(sel_len == SU + PW + RV, "R8 write select length", sel_len, SU + PW + RV);
               chk(we_fall_at == SU, "R8 setup before strobe", we_fall_at, SU);
            end
            sel_len = 0; in_wr = 0;
         end
         prev_sel = sel; prev_addr = mem_addr; prev_we = mem_we_n;
         prev_dq = mem_dq_o; prev_rsp = rsp_valid;
      end
   end

   // ---------------- watchdog ----------------
   bit finished = 0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         chk(0, "R1 watchdog expired", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
          "R1 reset outputs", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid},
          6'b101100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

      // writes at both address ends and assorted data, issued back to back (R10)
      issue(1, 13'h0000, 8'hA5);
      issue(1, 13'h1FFF, 8'h5A);
      issue(1, 13'h0ABC, 8'hFF);
      issue(1, 13'h0123, 8'h00);
      chk(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
      issue(0, 13'h0000, 8'h00);
      issue(0, 13'h1FFF, 8'h00);
      issue(0, 13'h0ABC, 8'h00);
      issue(0, 13'h0123, 8'h00);
      // overwrite then read back, read of an untouched word
      issue(1, 13'h0ABC, 8'h3C);
      issue(0, 13'h0ABC, 8'h00);
      issue(0, 13'h0777, 8'h00);
      // isolated accesses with idle gaps
      repeat (3) @(negedge clk);
      issue(1, 13'h1555, 8'h81);
      repeat (5) @(negedge clk);
      issue(0, 13'h1555, 8'h00);
      // walking data pattern
      for (int i = 0; i < 8; i++) issue(1, AW'(13'h0100 + i), DW'(1 << i));
      for (int i = 0; i < 8; i++) issue(0, AW'(13'h0100 + i), 8'h00);

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
      chk(n_rsp == n_reads, "R9 one response per read", n_rsp, n_reads);
      chk(n_sel == n_req, "R10 one access per request", n_sel, n_req);
      chk(bad_r1 == 0, "R1 ready only when quiet", bad_r1, 0);
      chk(bad_r2 == 0, "R2 selects paired", bad_r2, 0);
      chk(bad_r3 == 0, "R3 write strobe legal", bad_r3, 0);
      chk(bad_r4 == 0, "R4 bus drive legal", bad_r4, 0);
      chk(bad_r5 == 0, "R5 address stable", bad_r5, 0);
      chk(bad_r9 == 0, "R9 single pulse", bad_r9, 0);
      chk(bad_r11 == 0, "R11 idle deselect", bad_r11, 0);
      chk(mem_ce1_n && !mem_ce2, "R11 deselected at end", {mem_ce1_n, mem_ce2}, 2'b10);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule